// File: doc/BRIEF.md
# Delayed Read Reservation Timer

This block makes the retry decision for a bus target that serves reads to external masters. When a read is accepted, the block asks the read path to fetch the data. If the fetch finishes within a fixed completion deadline, the read is answered with data. If it does not, the master is told to retry. From that moment a programmable lifetime counts down, and the fetched data is kept reserved for that master and address alone.

The reservation ends in one of two ways. The original master may come back with the same address while the data is present: the read is then answered with data and the reservation is released. Otherwise the lifetime runs out and the data is thrown away. While the target is busy, every other request is answered with a retry and has no effect on the reserved read.

Requests, completions and configuration writes are single-cycle strobes sampled on the rising clock edge. Every output changes on the edge that samples its cause, so it is visible in the following cycle.

Top module: `delayed_read_keeper`

## Requirements
- R1: After reset, cfgRdData reads 0x00008000 and retry, deliver, fetchReq and holdValid are all low.
- R2: A configuration write loads cfgWrLife into the lifetime, which reads back zero-extended to 32 bits on cfgRdData; bits 31:16 read as zero.
- R3: A request accepted while idle raises fetchReq for one cycle. If fetchDone is sampled on any of the 16 edges that follow the accepting edge, deliver pulses after that edge and no retry is given.
- R4: If fetchDone has not been sampled by the 16th edge after the accepting edge, retry pulses after that 16th edge. No retry comes earlier.
- R5: After the retry, fetchDone raises holdValid on the edge that samples it, provided the lifetime has not run out on that edge.
- R6: A request carrying the reserved master and address, sampled while holdValid is high, pulses deliver and clears holdValid on the same edge. The block is then idle.
- R7: With lifetime L loaded at the retry edge r, an unclaimed reservation is discarded on edge r+L+1. holdValid is low afterwards and the next request starts a new fetch.
- R8: A lifetime of zero discards the reservation on the edge after the retry, even if fetchDone arrives on that edge.
- R9: While a reservation is active, a request with a different master or a different address is answered with retry. It leaves holdValid and the reserved data untouched, and no fetch starts.
- R10: A matching request that arrives before the data is present is answered with retry and does not restart or stop the lifetime countdown.
- R11: A request sampled while a fetch is still inside its deadline is answered with retry, starts no fetch, and does not disturb the outstanding read.
- R12: A lifetime write during an active reservation does not change that reservation's countdown. It takes effect from the next retry.

Ports are listed below; the parameters are MASTER_W=3, ADDR_W=32, LIFE_W=16 and DEADLINE=16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Lifetime register write strobe |
| cfgWrLife | input | 16 | New lifetime value, in bus clocks |
| cfgRdData | output | 32 | Lifetime register readback, zero-extended |
| reqValid | input | 1 | Read request from an external master |
| reqMaster | input | 3 | Identity of the requesting master |
| reqAddr | input | 32 | Address of the requested read |
| fetchReq | output | 1 | Pulse asking the read path to fetch the accepted read |
| fetchDone | input | 1 | Read path completion strobe |
| retry | output | 1 | Pulse answering a request with retry |
| deliver | output | 1 | Pulse answering the pending read with data |
| holdValid | output | 1 | Fetched data is present and reserved |

## Verification
The bench places completions on the 16th edge after acceptance and then one edge later. A design with an off-by-one deadline would retry a read that was on time, or deliver one that was late. It runs the lifetime at zero and at small values and checks the exact edge where holdValid drops; a countdown that starts at the wrong edge or stops one early or one late shows up there. It sends strangers, wrong addresses and an early matching request into an active reservation. A block that matches only on address, or that restarts its timer, would deliver to the wrong party or keep the data past its expiry. It also rewrites the lifetime in the middle of a reservation, which catches a timer that reads the register live instead of a loaded copy.

// File: rtl/drk_pkg.sv
package drk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } drk_state_e;

  typedef struct packed {
    logic captureTag;
    logic clearWait;
    logic bumpWait;
    logic loadTimer;
    logic tickTimer;
    logic setData;
    logic dropData;
  } drk_strobe_t;

endpackage

// File: rtl/drk_datapath.sv
module drk_datapath
  import drk_pkg::*;
#(
  parameter int MASTER_W = 3,
  parameter int ADDR_W = 32,
  parameter int LIFE_W = 16,
  parameter int DEADLINE = 16,
  parameter logic [LIFE_W-1:0] RESET_LIFE = LIFE_W'(16'h8000)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [LIFE_W-1:0]   cfgWrLife,
  input  logic [MASTER_W-1:0] reqMaster,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  drk_strobe_t         strobe,
  output logic [LIFE_W-1:0]   lifeValue,
  output logic                tagMatch,
  output logic                waitLast,
  output logic                timerZero,
  output logic                dataHere
);

  localparam int WAIT_W = (DEADLINE > 1) ? $clog2(DEADLINE) : 1;
  localparam logic [WAIT_W-1:0] WAIT_END = WAIT_W'(DEADLINE - 1);

  logic [LIFE_W-1:0]   lifeReg;
  logic [LIFE_W-1:0]   timer;
  logic [WAIT_W-1:0]   waitCnt;
  logic [MASTER_W-1:0] tagMaster;
  logic [ADDR_W-1:0]   tagAddr;

  // programmed lifetime
  always_ff @(posedge clk) begin
    if (!rstN) lifeReg <= RESET_LIFE;
    else if (cfgWrEn) lifeReg <= cfgWrLife;
  end

  // identity of the read that owns the reservation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagMaster <= '0;
      tagAddr   <= '0;
    end else if (strobe.captureTag) begin
      tagMaster <= reqMaster;
      tagAddr   <= reqAddr;
    end
  end

  // completion deadline counter
  always_ff @(posedge clk) begin
    if (!rstN) waitCnt <= '0;
    else if (strobe.clearWait) waitCnt <= '0;
    else if (strobe.bumpWait) waitCnt <= waitCnt + 1'b1;
  end

  // lifetime countdown, loaded from a copy of the register at retry time
  always_ff @(posedge clk) begin
    if (!rstN) timer <= '0;
    else if (strobe.loadTimer) timer <= lifeReg;
    else if (strobe.tickTimer) timer <= timer - 1'b1;
  end

  // data presence flag
  always_ff @(posedge clk) begin
    if (!rstN) dataHere <= 1'b0;
    else if (strobe.dropData) dataHere <= 1'b0;
    else if (strobe.setData) dataHere <= 1'b1;
  end

  assign lifeValue = lifeReg;
  assign tagMatch  = (reqMaster == tagMaster) && (reqAddr == tagAddr);
  assign waitLast  = (waitCnt == WAIT_END);
  assign timerZero = (timer == '0);

endmodule

// File: rtl/drk_ctrl.sv
module drk_ctrl
  import drk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        fetchDone,
  input  logic        tagMatch,
  input  logic        waitLast,
  input  logic        timerZero,
  input  logic        dataHere,
  output drk_strobe_t strobe,
  output logic        fetchReq,
  output logic        retry,
  output logic        deliver
);

  drk_state_e state, stateNext;
  logic fetchNext, retryNext, deliverNext;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    fetchNext   = 1'b0;
    retryNext   = 1'b0;
    deliverNext = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.captureTag = 1'b1;
          strobe.clearWait  = 1'b1;
          fetchNext         = 1'b1;
          stateNext         = ST_WAIT;
        end
      end
      ST_WAIT: begin
        // busy: any new request is turned away
        retryNext = reqValid;
        if (fetchDone) begin
          deliverNext = 1'b1;
          stateNext   = ST_IDLE;
        end else if (waitLast) begin
          retryNext        = 1'b1;
          strobe.loadTimer = 1'b1;
          stateNext        = ST_HOLD;
        end else begin
          strobe.bumpWait = 1'b1;
        end
      end
      ST_HOLD: begin
        if (reqValid && tagMatch && dataHere) begin
          deliverNext     = 1'b1;
          strobe.dropData = 1'b1;
          stateNext       = ST_IDLE;
        end else begin
          retryNext = reqValid;
          if (timerZero) begin
            strobe.dropData = 1'b1;
            stateNext       = ST_IDLE;
          end else begin
            strobe.tickTimer = 1'b1;
            strobe.setData   = fetchDone;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fetchReq <= 1'b0;
      retry    <= 1'b0;
      deliver  <= 1'b0;
    end else begin
      state    <= stateNext;
      fetchReq <= fetchNext;
      retry    <= retryNext;
      deliver  <= deliverNext;
    end
  end

endmodule

// File: rtl/delayed_read_keeper.sv
module delayed_read_keeper
  import drk_pkg::*;
#(
  parameter int MASTER_W = 3,
  parameter int ADDR_W = 32,
  parameter int LIFE_W = 16,
  parameter int DEADLINE = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [LIFE_W-1:0]   cfgWrLife,
  output logic [31:0]         cfgRdData,
  input  logic                reqValid,
  input  logic [MASTER_W-1:0] reqMaster,
  input  logic [ADDR_W-1:0]   reqAddr,
  output logic                fetchReq,
  input  logic                fetchDone,
  output logic                retry,
  output logic                deliver,
  output logic                holdValid
);

  drk_strobe_t strobe;
  logic [LIFE_W-1:0] lifeValue;
  logic tagMatch, waitLast, timerZero, dataHere;

  drk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fetchDone(fetchDone),
    .tagMatch(tagMatch), .waitLast(waitLast), .timerZero(timerZero),
    .dataHere(dataHere), .strobe(strobe), .fetchReq(fetchReq),
    .retry(retry), .deliver(deliver)
  );

  drk_datapath #(
    .MASTER_W(MASTER_W), .ADDR_W(ADDR_W), .LIFE_W(LIFE_W), .DEADLINE(DEADLINE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrLife(cfgWrLife),
    .reqMaster(reqMaster), .reqAddr(reqAddr), .strobe(strobe),
    .lifeValue(lifeValue), .tagMatch(tagMatch), .waitLast(waitLast),
    .timerZero(timerZero), .dataHere(dataHere)
  );

  assign cfgRdData = 32'(lifeValue);
  assign holdValid = dataHere;

endmodule

// File: rtl/drk_checker.sv
module drk_checker #(
  parameter int DEADLINE = 16
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic fetchDone,
  input logic fetchReq,
  input logic retry,
  input logic deliver,
  input logic holdValid
);

  localparam int CNT_W = $clog2(DEADLINE + 2) + 1;

  logic             pending;
  logic [CNT_W-1:0] age;

  // age of an outstanding fetch that has not yet been answered
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      age     <= '0;
    end else if (retry || deliver) begin
      pending <= 1'b0;
      age     <= '0;
    end else if (fetchReq) begin
      pending <= 1'b1;
      age     <= CNT_W'(1);
    end else if (pending) begin
      age <= age + 1'b1;
    end
  end

  assert_deadline_R4: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> (age <= CNT_W'(DEADLINE)));

  assert_fetch_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> $past(reqValid));

  assert_hold_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdValid) |-> $past(fetchDone));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    deliver |-> !holdValid);

  assert_no_fetch_in_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    holdValid |-> !fetchReq);

endmodule

bind delayed_read_keeper drk_checker #(.DEADLINE(DEADLINE)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .fetchDone(fetchDone),
  .fetchReq(fetchReq), .retry(retry), .deliver(deliver), .holdValid(holdValid)
);

// File: tb/tb_delayed_read_keeper.sv
module tb_delayed_read_keeper;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [15:0] cfgWrLife = '0;
  logic [31:0] cfgRdData;
  logic        reqValid = 1'b0;
  logic [2:0]  reqMaster = '0;
  logic [31:0] reqAddr = '0;
  logic        fetchReq;
  logic        fetchDone = 1'b0;
  logic        retry;
  logic        deliver;
  logic        holdValid;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  delayed_read_keeper dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrLife(cfgWrLife),
    .cfgRdData(cfgRdData), .reqValid(reqValid), .reqMaster(reqMaster),
    .reqAddr(reqAddr), .fetchReq(fetchReq), .fetchDone(fetchDone),
    .retry(retry), .deliver(deliver), .holdValid(holdValid)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // drive a request for one edge; returns at the negedge after it is sampled
  task automatic issueReq(logic [2:0] m, logic [31:0] a);
    reqValid = 1'b1; reqMaster = m; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic pulseDone();
    fetchDone = 1'b1;
    @(negedge clk);
    fetchDone = 1'b0;
  endtask

  task automatic writeLife(logic [15:0] v);
    cfgWrEn = 1'b1; cfgWrLife = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // accept a read, let it miss the deadline; returns at the negedge after retry edge r
  task automatic goToRetry(logic [2:0] m, logic [31:0] a);
    issueReq(m, a);
    check("R3", "fetchReq after accept", 32'(fetchReq), 32'd1);
    repeat (15) @(negedge clk);
    check("R4", "no retry before 16th edge", 32'(retry), 32'd0);
    @(negedge clk);
    check("R4", "retry after 16th edge", 32'(retry), 32'd1);
  endtask

  task automatic t_reset();
    check("R1", "cfgRdData", cfgRdData, 32'h0000_8000);
    check("R1", "outputs idle", {28'd0, retry, deliver, fetchReq, holdValid}, 32'd0);
  endtask

  task automatic t_cfg();
    writeLife(16'h1234);
    check("R2", "readback zero-extended", cfgRdData, 32'h0000_1234);
  endtask

  task automatic t_fast();
    issueReq(3'd1, 32'h100);
    check("R3", "fetchReq", 32'(fetchReq), 32'd1);
    repeat (4) @(negedge clk);
    pulseDone();
    check("R3", "early deliver", 32'(deliver), 32'd1);
    check("R3", "early no retry", 32'(retry), 32'd0);
    // completion exactly on the 16th edge
    issueReq(3'd1, 32'h104);
    repeat (15) @(negedge clk);
    pulseDone();
    check("R3", "deliver on 16th edge", 32'(deliver), 32'd1);
    check("R3", "no retry on 16th edge", 32'(retry), 32'd0);
    @(negedge clk);
  endtask

  task automatic t_expiry();
    writeLife(16'd5);
    goToRetry(3'd2, 32'h200);
    pulseDone();
    check("R5", "holdValid after data", 32'(holdValid), 32'd1);
    repeat (4) @(negedge clk);
    check("R7", "held at r+L", 32'(holdValid), 32'd1);
    @(negedge clk);
    check("R7", "discard at r+L+1", 32'(holdValid), 32'd0);
    issueReq(3'd2, 32'h200);
    check("R7", "new fetch after expiry", 32'(fetchReq), 32'd1);
    check("R7", "no deliver after expiry", 32'(deliver), 32'd0);
    pulseDone();
    @(negedge clk);
  endtask

  task automatic t_zero();
    writeLife(16'd0);
    goToRetry(3'd3, 32'h300);
    pulseDone();
    check("R8", "zero lifetime discards at r+1", 32'(holdValid), 32'd0);
    issueReq(3'd3, 32'h300);
    check("R8", "idle after zero lifetime", 32'(fetchReq), 32'd1);
    pulseDone();
    @(negedge clk);
  endtask

  task automatic t_match();
    writeLife(16'd20);
    goToRetry(3'd2, 32'h400);
    pulseDone();
    @(negedge clk);
    issueReq(3'd2, 32'h400);
    check("R6", "deliver to owner", 32'(deliver), 32'd1);
    check("R6", "no retry to owner", 32'(retry), 32'd0);
    check("R6", "hold released", 32'(holdValid), 32'd0);
    issueReq(3'd5, 32'h500);
    check("R6", "idle after delivery", 32'(fetchReq), 32'd1);
    pulseDone();
    @(negedge clk);
  endtask

  task automatic t_foreign();
    writeLife(16'd40);
    goToRetry(3'd2, 32'h600);
    pulseDone();
    issueReq(3'd3, 32'h600);
    check("R9", "other master retried", 32'(retry), 32'd1);
    check("R9", "other master no fetch", 32'(fetchReq), 32'd0);
    check("R9", "hold kept (master)", 32'(holdValid), 32'd1);
    issueReq(3'd2, 32'h604);
    check("R9", "other address retried", 32'(retry), 32'd1);
    check("R9", "hold kept (address)", 32'(holdValid), 32'd1);
    issueReq(3'd2, 32'h600);
    check("R9", "owner still served", 32'(deliver), 32'd1);
    @(negedge clk);
  endtask

  task automatic t_early();
    writeLife(16'd6);
    goToRetry(3'd1, 32'h700);
    issueReq(3'd1, 32'h700);
    check("R10", "early owner retried", 32'(retry), 32'd1);
    check("R10", "early owner no deliver", 32'(deliver), 32'd0);
    pulseDone();
    check("R10", "data held after arrival", 32'(holdValid), 32'd1);
    repeat (4) @(negedge clk);
    check("R10", "held at r+L", 32'(holdValid), 32'd1);
    @(negedge clk);
    check("R10", "expires at r+L+1", 32'(holdValid), 32'd0);
  endtask

  task automatic t_busy();
    issueReq(3'd1, 32'h800);
    repeat (2) @(negedge clk);
    issueReq(3'd4, 32'h900);
    check("R11", "busy request retried", 32'(retry), 32'd1);
    check("R11", "busy request no fetch", 32'(fetchReq), 32'd0);
    pulseDone();
    check("R11", "original read delivered", 32'(deliver), 32'd1);
    @(negedge clk);
  endtask

  task automatic t_reload();
    writeLife(16'd4);
    goToRetry(3'd6, 32'hA00);
    cfgWrEn = 1'b1; cfgWrLife = 16'd100; fetchDone = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0; fetchDone = 1'b0;
    check("R12", "held after data", 32'(holdValid), 32'd1);
    repeat (3) @(negedge clk);
    check("R12", "held at r+4", 32'(holdValid), 32'd1);
    @(negedge clk);
    check("R12", "old lifetime used", 32'(holdValid), 32'd0);
    check("R12", "new value stored", cfgRdData, 32'd100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_fast();
    t_expiry();
    t_zero();
    t_match();
    t_foreign();
    t_early();
    t_busy();
    t_reload();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule